// File: doc/BRIEF.md
# Add-Only Memory Command Controller

This block is the command layer of a one-time-programmable store. The main data field holds 128 bytes as four 32-byte pages. A separate 8-byte status field holds the page protection bits and one spare byte per page that software uses to mark a page as superseded. Bytes arrive from a serial link layer as a byte stream. Each transaction opens with a command byte and a 16-bit start address, low byte first. The master then either pulls read bytes out one at a time, or sends data bytes for programming. Each data byte is held in an 8-bit scratchpad and answered with a CRC. The byte is committed only when the programming-voltage detector strobes.

The storage cells are behavioural models with add-only semantics. A program operation can only clear bits, so the stored word becomes the old word AND the new word. A bus reset from the link layer ends any transaction at once. The link layer, device selection and the analog voltage detector stay outside the block.

Top module: `aom_ctrl`

## Requirements
- R1: After reset every location of both fields reads FFh. Command F0h reads the main field (128 bytes) and command AAh reads the status field (8 bytes). Each command is followed by address low, then address high.
- R2: In a read, each `rd_req` pulse returns, on the next clock edge, `tx_valid` high for one cycle and `tx_data` equal to the byte at the current address. The address then steps up by one.
- R3: After the last byte of the selected field has been returned, the controller is idle. A later `rd_req` returns FFh, and the next received byte is decoded as a command.
- R4: Command 0Fh writes the main field and command 55h writes the status field. The byte after the header loads the scratchpad. One cycle later `tx_valid` carries a CRC-8 (polynomial x^8+x^5+x^4+1, bits taken LSB first, reflected constant 8Ch, seed 00h) over every byte received since and including the command byte.
- R5: A `prog_pulse` with a loaded scratchpad stores (old AND scratchpad) at the current address. No stored bit ever changes from 0 to 1.
- R6: After a commit the address steps up by one and the next data byte is accepted without a new header. A commit at the last address of the field ends the transaction.
- R7: A cleared bit n of status byte 0 protects main page n (addresses 32n to 32n+31). A commit into a protected page leaves the array unchanged and returns the controller to idle. Reads of that page still work, and other pages can still be written.
- R8: Status bytes 1 to 4 are stored and read back like any status byte. Their contents have no effect on main-field access.
- R9: A command byte other than F0h, AAh, 0Fh or 55h is ignored, and the controller stays idle.
- R10: A `prog_pulse` that arrives when no scratchpad byte is loaded is ignored and returns the controller to idle.
- R11: `bus_rst` aborts any transaction. A later `prog_pulse` commits nothing.
- R12: A start address at or beyond the end of the selected field ends the transaction. The controller returns to idle.
- R13: While in reset and immediately after it, `tx_valid` is 0 and `tx_data` is FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also erases the behavioural cells |
| bus_rst | input | 1 | Link-layer bus reset pulse, aborts the transaction |
| rx_valid | input | 1 | A byte from the master is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Master requests one byte to be returned |
| prog_pulse | input | 1 | Programming-voltage detected strobe |
| tx_valid | output | 1 | One-cycle flag: `tx_data` holds a returned byte or CRC |
| tx_data | output | 8 | Returned byte, CRC, or FFh when idle |

## Verification
The bench builds the block with its default parameters: four pages of 32 bytes, an 8-byte status field and protection enabled. At that size, the last main address 7Fh and the out-of-range address 80h are only a header away. A page boundary at 20h separates the protected page from its unprotected neighbour. The CRC continuation across back-to-back commits, the AND merge of a second write to the same byte, and a page redirect that must not change main reads are all exercised at these sizes.

// File: rtl/aom_pkg.sv
package aom_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HDR_LO,
      S_HDR_HI,
      S_READ,
      S_WDATA,
      S_WPROG
   } ctl_state_e;

   localparam logic [7:0] CMD_RD_MAIN = 8'hF0;
   localparam logic [7:0] CMD_RD_STAT = 8'hAA;
   localparam logic [7:0] CMD_WR_MAIN = 8'h0F;
   localparam logic [7:0] CMD_WR_STAT = 8'h55;

   localparam logic [7:0] ERASED = 8'hFF;

   // one byte through the reflected x^8+x^5+x^4+1 shifter, LSB first
   function automatic logic [7:0] crc8_step(input logic [7:0] seed, input logic [7:0] din);
      logic [7:0] c;
      logic       fb;
      c = seed;
      for (int i = 0; i < 8; i++) begin
         fb = c[0] ^ din[i];
         c  = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

endpackage

// File: rtl/aom_otp_array.sv
module aom_otp_array #(
   parameter int DEPTH = 128,
   parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   output logic [7:0]    tap0
);

   logic [7:0] cells [DEPTH];

   // cells power up erased; a program only clears bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (we) begin
         cells[addr] <= cells[addr] & wdata;
      end
   end

   assign rdata = cells[addr];
   assign tap0  = cells[0];

   // R5: a written cell never gains a set bit
   p_add_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((~$past(rdata)) & cells[$past(addr)]) == 8'h00);

   // R5: the word at location 0 never gains a set bit either
   p_tap_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((~$past(tap0)) & tap0) == 8'h00);

endmodule

// File: rtl/aom_crc8.sv
module aom_crc8 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] din,
   output logic [7:0] crc_nxt
);
   import aom_pkg::*;

   logic [7:0] acc;

   assign crc_nxt = crc8_step(clr ? 8'h00 : acc, din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= 8'h00;
      else if (en) acc <= crc_nxt;
   end

endmodule

// File: rtl/aom_ctrl.sv
module aom_ctrl #(
   parameter int PAGES      = 4,
   parameter int PAGE_BYTES = 32,
   parameter int STAT_BYTES = 8,
   parameter bit WP_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rd_req,
   input  logic       prog_pulse,
   output logic       tx_valid,
   output logic [7:0] tx_data
);
   import aom_pkg::*;

   localparam int MAIN_BYTES = PAGES * PAGE_BYTES;
   localparam int MAW        = $clog2(MAIN_BYTES);
   localparam int SAW        = $clog2(STAT_BYTES);
   localparam int PGW        = $clog2(PAGES);
   localparam logic [16:0] MAIN_LIM  = 17'(MAIN_BYTES);
   localparam logic [16:0] STAT_LIM  = 17'(STAT_BYTES);
   localparam logic [15:0] MAIN_LAST = 16'(MAIN_BYTES - 1);
   localparam logic [15:0] STAT_LAST = 16'(STAT_BYTES - 1);

   // elaboration-time parameter checks
   if (PAGES < 2 || PAGES > 8) begin : g_bad_pages
      $error("aom_ctrl: PAGES must lie in 2..8");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_pbytes
      $error("aom_ctrl: PAGE_BYTES must be a power of two");
   end
   if (STAT_BYTES < PAGES + 1 || (STAT_BYTES & (STAT_BYTES - 1)) != 0) begin : g_bad_sbytes
      $error("aom_ctrl: STAT_BYTES must be a power of two holding protect plus redirect bytes");
   end
   if (MAIN_BYTES > 4096) begin : g_bad_size
      $error("aom_ctrl: main field too large for the behavioural model");
   end

   ctl_state_e st;
   logic       is_stat;     // field select: 0 main, 1 status
   logic       is_wr;
   logic [15:0] addr;
   logic [7:0]  scratch;

   logic [7:0] main_rd, stat_rd, main_tap, stat_tap;
   logic       main_we, stat_we;
   logic [7:0] crc_nxt;
   logic       crc_en, crc_clr;
   logic [PAGES-1:0] prot;
   logic       prot_hit, commit_try, at_last, hdr_oob;
   logic [PGW-1:0] page;
   logic       unused_taps;

   assign unused_taps = ^{main_tap, stat_tap[7:PAGES]};

   // ---------------- protection decode ----------------
   for (genvar p = 0; p < PAGES; p++) begin : g_prot
      if (WP_EN) begin : g_on
         assign prot[p] = ~stat_tap[p];
      end else begin : g_off
         assign prot[p] = 1'b0;
      end
   end

   assign page     = addr[MAW-1 -: PGW];
   assign prot_hit = prot[page];

   assign commit_try = (st == S_WPROG) && prog_pulse && !bus_rst;
   assign main_we    = commit_try && !is_stat && !prot_hit;
   assign stat_we    = commit_try && is_stat;

   assign at_last = is_stat ? (addr == STAT_LAST) : (addr == MAIN_LAST);
   assign hdr_oob = ({1'b0, rx_data, addr[7:0]} >= (is_stat ? STAT_LIM : MAIN_LIM));

   assign crc_clr = (st == S_IDLE);
   assign crc_en  = rx_valid && !bus_rst &&
                    (st == S_IDLE || st == S_HDR_LO || st == S_HDR_HI || st == S_WDATA);

   // ---------------- storage and CRC ----------------
   aom_otp_array #(.DEPTH(MAIN_BYTES), .AW(MAW)) u_main (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (main_we),
      .addr  (addr[MAW-1:0]),
      .wdata (scratch),
      .rdata (main_rd),
      .tap0  (main_tap)
   );

   aom_otp_array #(.DEPTH(STAT_BYTES), .AW(SAW)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (stat_we),
      .addr  (addr[SAW-1:0]),
      .wdata (scratch),
      .rdata (stat_rd),
      .tap0  (stat_tap)
   );

   aom_crc8 u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (crc_clr),
      .en      (crc_en),
      .din     (rx_data),
      .crc_nxt (crc_nxt)
   );

   // ---------------- command sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         is_stat  <= 1'b0;
         is_wr    <= 1'b0;
         addr     <= '0;
         scratch  <= ERASED;
         tx_valid <= 1'b0;
         tx_data  <= ERASED;
      end else begin
         tx_valid <= 1'b0;
         if (bus_rst) begin
            st <= S_IDLE;
         end else begin
            if (rd_req) begin
               tx_valid <= 1'b1;
               tx_data  <= ERASED;
            end
            case (st)
               S_IDLE: begin
                  if (rx_valid) begin
                     case (rx_data)
                        CMD_RD_MAIN: begin is_stat <= 1'b0; is_wr <= 1'b0; st <= S_HDR_LO; end
                        CMD_RD_STAT: begin is_stat <= 1'b1; is_wr <= 1'b0; st <= S_HDR_LO; end
                        CMD_WR_MAIN: begin is_stat <= 1'b0; is_wr <= 1'b1; st <= S_HDR_LO; end
                        CMD_WR_STAT: begin is_stat <= 1'b1; is_wr <= 1'b1; st <= S_HDR_LO; end
                        default:     st <= S_IDLE;
                     endcase
                  end
               end
               S_HDR_LO: begin
                  if (prog_pulse)    st <= S_IDLE;
                  else if (rx_valid) begin
                     addr[7:0] <= rx_data;
                     st        <= S_HDR_HI;
                  end
               end
               S_HDR_HI: begin
                  if (prog_pulse)    st <= S_IDLE;
                  else if (rx_valid) begin
                     addr[15:8] <= rx_data;
                     if (hdr_oob)    st <= S_IDLE;
                     else if (is_wr) st <= S_WDATA;
                     else            st <= S_READ;
                  end
               end
               S_READ: begin
                  if (prog_pulse) begin
                     st <= S_IDLE;
                  end else if (rd_req) begin
                     tx_data <= is_stat ? stat_rd : main_rd;
                     if (at_last) st <= S_IDLE;
                     else         addr <= addr + 16'd1;
                  end
               end
               S_WDATA: begin
                  if (prog_pulse) begin
                     st <= S_IDLE;
                  end else if (rx_valid) begin
                     scratch  <= rx_data;
                     tx_valid <= 1'b1;
                     tx_data  <= crc_nxt;
                     st       <= S_WPROG;
                  end
               end
               S_WPROG: begin
                  if (prog_pulse) begin
                     if (!is_stat && prot_hit) st <= S_IDLE;
                     else if (at_last)         st <= S_IDLE;
                     else begin
                        addr <= addr + 16'd1;
                        st   <= S_WDATA;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   // R11: a bus reset always lands in idle with nothing returned
   p_bus_rst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (st == S_IDLE) && !tx_valid);

   // R2: a returned byte is always caused by a request or a received data byte
   p_tx_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(rd_req || rx_valid));

   // R3: the final byte of a field ends the read
   p_end_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_READ && rd_req && at_last && !bus_rst && !prog_pulse) |=> st == S_IDLE);

   // R7: a commit into a protected page leaves the cell untouched
   p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_try && !is_stat && prot_hit) |=> $stable(main_rd));

   // R5: at most one field is programmed per cycle
   p_one_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({main_we, stat_we}));

   // R10: a strobe while waiting for data abandons the transaction
   p_bare_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WDATA && prog_pulse && !bus_rst) |=> st == S_IDLE);

endmodule

// File: tb/aom_ctrl_test.sv
module aom_ctrl_test;

   localparam int OP_RX = 0;  // send byte
   localparam int OP_RD = 1;  // request byte, expect value
   localparam int OP_PG = 2;  // programming strobe
   localparam int OP_BR = 3;  // bus reset
   localparam int OP_RC = 4;  // send byte, expect CRC

   function automatic logic [15:0] mk(int op, int st, int tag, logic [7:0] v);
      return {3'(op), 1'(st), 4'(tag), v};
   endfunction

   localparam int NV = 61;
   localparam logic [15:0] VEC [NV] = '{
      // R1 erased field, R2 stepping read
      mk(OP_RX,1,0,8'hF0), mk(OP_RX,0,0,8'h00), mk(OP_RX,0,0,8'h00),
      mk(OP_RD,0,1,8'hFF), mk(OP_RD,0,2,8'hFF), mk(OP_BR,0,0,8'h00),
      // R4 CRC, R5 commit, R6 continuation at address 6
      mk(OP_RX,1,0,8'h0F), mk(OP_RX,0,0,8'h05), mk(OP_RX,0,0,8'h00),
      mk(OP_RC,0,4,8'hA5), mk(OP_PG,0,0,8'h00), mk(OP_RC,0,6,8'h3C),
      mk(OP_PG,0,0,8'h00), mk(OP_BR,0,0,8'h00),
      // R2 read back, R6 second byte
      mk(OP_RX,1,0,8'hF0), mk(OP_RX,0,0,8'h05), mk(OP_RX,0,0,8'h00),
      mk(OP_RD,0,2,8'hA5), mk(OP_RD,0,6,8'h3C), mk(OP_RD,0,2,8'hFF),
      mk(OP_BR,0,0,8'h00),
      // R5 AND merge: A5 & F0 = A0
      mk(OP_RX,1,0,8'h0F), mk(OP_RX,0,0,8'h05), mk(OP_RX,0,0,8'h00),
      mk(OP_RC,0,4,8'hF0), mk(OP_PG,0,0,8'h00), mk(OP_BR,0,0,8'h00),
      mk(OP_RX,1,0,8'hF0), mk(OP_RX,0,0,8'h05), mk(OP_RX,0,0,8'h00),
      mk(OP_RD,0,5,8'hA0), mk(OP_BR,0,0,8'h00),
      // R7 protect page 1 (status byte 0 = FD)
      mk(OP_RX,1,0,8'h55), mk(OP_RX,0,0,8'h00), mk(OP_RX,0,0,8'h00),
      mk(OP_RC,0,4,8'hFD), mk(OP_PG,0,0,8'h00), mk(OP_BR,0,0,8'h00),
      // R7 refused commit at 25h, then controller idle and page readable
      mk(OP_RX,1,0,8'h0F), mk(OP_RX,0,0,8'h25), mk(OP_RX,0,0,8'h00),
      mk(OP_RC,0,4,8'h00), mk(OP_PG,0,0,8'h00),
      mk(OP_RX,1,0,8'hF0), mk(OP_RX,0,0,8'h25), mk(OP_RX,0,0,8'h00),
      mk(OP_RD,0,7,8'hFF), mk(OP_BR,0,0,8'h00),
      // R8 redirect byte for page 1 points at page 2
      mk(OP_RX,1,0,8'h55), mk(OP_RX,0,0,8'h02), mk(OP_RX,0,0,8'h00),
      mk(OP_RC,0,4,8'hFD), mk(OP_PG,0,0,8'h00), mk(OP_BR,0,0,8'h00),
      mk(OP_RX,1,0,8'hAA), mk(OP_RX,0,0,8'h00), mk(OP_RX,0,0,8'h00),
      mk(OP_RD,0,7,8'hFD), mk(OP_RD,0,8,8'hFF), mk(OP_RD,0,8,8'hFD),
      mk(OP_BR,0,0,8'h00)
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rd_req = 1'b0;
   logic       prog_pulse = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_data;

   int nchk = 0;
   int nfail = 0;
   logic [7:0] acc = 8'h00;

   always #4 clk = ~clk;

   aom_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_rst    (bus_rst),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rd_req     (rd_req),
      .prog_pulse (prog_pulse),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data)
   );

   function automatic logic [7:0] crc_ref(logic [7:0] s, logic [7:0] d);
      logic [7:0] c = s;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
         else             c = c >> 1;
      end
      return c;
   endfunction

   task automatic check(int tag, logic [7:0] expv);
      nchk++;
      if (tx_valid !== 1'b1 || tx_data !== expv) begin
         nfail++;
         $display("FAIL R%0d: tx_valid=%0b tx_data=%02h expected valid=1 data=%02h",
                  tag, tx_valid, tx_data, expv);
      end
   endtask

   task automatic do_op(int op, int st, int tag, logic [7:0] v);
      case (op)
         OP_RX, OP_RC: begin
            if (st != 0) acc = 8'h00;
            acc = crc_ref(acc, v);
            @(negedge clk); rx_valid = 1'b1; rx_data = v;
            @(negedge clk); rx_valid = 1'b0;
            if (op == OP_RC) check(tag, acc);
         end
         OP_RD: begin
            @(negedge clk); rd_req = 1'b1;
            @(negedge clk); rd_req = 1'b0;
            check(tag, v);
         end
         OP_PG: begin
            @(negedge clk); prog_pulse = 1'b1;
            @(negedge clk); prog_pulse = 1'b0;
         end
         default: begin
            @(negedge clk); bus_rst = 1'b1;
            @(negedge clk); bus_rst = 1'b0;
         end
      endcase
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R13 reset state
      repeat (3) @(negedge clk);
      nchk++;
      if (tx_valid !== 1'b0 || tx_data !== 8'hFF) begin
         nfail++;
         $display("FAIL R13: in reset tx_valid=%0b tx_data=%02h expected 0/FF", tx_valid, tx_data);
      end
      rst_n = 1'b1;
      @(negedge clk);
      nchk++;
      if (tx_valid !== 1'b0 || tx_data !== 8'hFF) begin
         nfail++;
         $display("FAIL R13: after reset tx_valid=%0b tx_data=%02h expected 0/FF", tx_valid, tx_data);
      end

      for (int i = 0; i < NV; i++)
         do_op(int'(VEC[i][15:13]), int'(VEC[i][12]), int'(VEC[i][11:8]), VEC[i][7:0]);

      // R9 unknown command is dropped, following F0 still decodes
      do_op(OP_RX,1,0,8'h33);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h05); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,9,8'hA0); do_op(OP_BR,0,0,8'h00);

      // R10 strobe before any data byte: nothing stored, controller idle
      do_op(OP_RX,1,0,8'h0F); do_op(OP_RX,0,0,8'h07); do_op(OP_RX,0,0,8'h00);
      do_op(OP_PG,0,0,8'h00);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h07); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,10,8'hFF); do_op(OP_BR,0,0,8'h00);

      // R6 commit at last main address ends write; R3 end of read field
      do_op(OP_RX,1,0,8'h0F); do_op(OP_RX,0,0,8'h7F); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RC,0,4,8'h5A); do_op(OP_PG,0,0,8'h00);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h7F); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,6,8'h5A);
      do_op(OP_RD,0,3,8'hFF);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h05); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,3,8'hA0); do_op(OP_BR,0,0,8'h00);

      // R12 start addresses 0080h and 0105h fall outside the main field
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h80); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,12,8'hFF);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h05); do_op(OP_RX,0,0,8'h01);
      do_op(OP_RD,0,12,8'hFF);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h05); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,12,8'hA0); do_op(OP_BR,0,0,8'h00);

      // R11 bus reset between data byte and strobe: address 6 keeps 3C
      do_op(OP_RX,1,0,8'h0F); do_op(OP_RX,0,0,8'h06); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RC,0,4,8'h00); do_op(OP_BR,0,0,8'h00); do_op(OP_PG,0,0,8'h00);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h06); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,11,8'h3C); do_op(OP_BR,0,0,8'h00);

      // R7 unprotected page 2 still programs; R8 redirect does not move page 1 reads
      do_op(OP_RX,1,0,8'h0F); do_op(OP_RX,0,0,8'h45); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RC,0,4,8'h12); do_op(OP_PG,0,0,8'h00); do_op(OP_BR,0,0,8'h00);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h45); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,7,8'h12); do_op(OP_BR,0,0,8'h00);
      do_op(OP_RX,1,0,8'hF0); do_op(OP_RX,0,0,8'h25); do_op(OP_RX,0,0,8'h00);
      do_op(OP_RD,0,8,8'hFF); do_op(OP_BR,0,0,8'h00);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule